// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block watches the write cycles a host issues to a flash device and turns them into commands for the array controller behind it. Commands are framed by two unlock cycles. A third cycle then picks the operation: a full program, entry to a shortened programming mode, or identifier mode for one bank. A single write anywhere drops the device back to plain array reads. In the shortened programming mode ("bypass") a program costs two bus writes instead of four. An acceleration input forces bypass while it is held.

When the identifier mode is entered, the bank number carried on the top three address bits of the third cycle is latched. From then on only reads that land in that bank are flagged for identifier data, and every other bank keeps delivering array data. A hardware reset input aborts the sequence in progress, forces read mode and rejects writes. After the reset the block holds a ready flag low for a recovery time. That time is long if the controller reported an embedded operation in progress when reset struck, and short otherwise.

The sequence states are `SEQ_IDLE` (no prefix seen), `SEQ_UNLK1` (first unlock seen), `SEQ_UNLK2` (both unlocks seen), `SEQ_PGM_DATA` (full program awaits its address and data), `SEQ_BYP_DATA` (bypass program awaits its address and data) and `SEQ_BYP_EXIT` (first bypass-exit cycle seen). The mode register takes the values `MODE_READ`, `MODE_ASEL` and `MODE_BYP`.

The transitions are:
- `SEQ_IDLE` goes to `SEQ_UNLK1` on AAh at 555h, outside bypass.
- `SEQ_UNLK1` goes to `SEQ_UNLK2` on 55h at 2AAh. Any other write returns it to `SEQ_IDLE`.
- `SEQ_UNLK2` at 555h goes to `SEQ_PGM_DATA` on A0h. On 20h it sets `MODE_BYP` and returns to idle. On 90h it sets `MODE_ASEL`, latches the bank and returns to idle. Anything else returns it to `SEQ_IDLE`.
- In bypass, `SEQ_IDLE` goes to `SEQ_BYP_DATA` on A0h and to `SEQ_BYP_EXIT` on 90h.
- `SEQ_BYP_EXIT` sets `MODE_READ` on 00h. Any write there returns it to idle.
- `SEQ_PGM_DATA` and `SEQ_BYP_DATA` issue a program on the next write and return to idle.
- F0h in idle sets `MODE_READ`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After power-up reset the mode output is 0 (read), ready is 1 and no strobe is active. Mode codes are 0 = read, 1 = identifier, 2 = bypass.
- R2: A full program needs four writes: AAh@555h, 55h@2AAh, A0h@555h, then the target write. Only the target write raises `prog_stb` for one cycle, in the cycle after that write. It also presents the target address and data on `cmd_addr`/`cmd_data`. Commands use `wr_data[7:0]` and address bits [10:0].
- R3: A write that does not match the expected unlock cycle returns the interpreter to idle. A later A0h write and a data write then produce no program.
- R4: The sequence AAh@555h, 55h@2AAh, 20h@555h sets mode 2. In mode 2, A0h at any address followed by one target write raises `prog_stb`.
- R5: In mode 2, writing 90h and then 00h returns the mode to 0. If the second write is not 00h, the mode stays 2.
- R6: The sequence AAh@555h, 55h@2AAh, 90h@555h sets mode 1. It pulses `asel_enter_stb` and latches `wr_addr[ADDR_W-1 -: 3]` on `asel_bank`. A later F0h write sets mode 0 and pulses `asel_exit_stb`.
- R7: In mode 1, `id_sel` is 1 only when the top three bits of `rd_addr` equal `asel_bank`, and is 0 for every other bank.
- R8: While `accel` is 1 the mode output reads 2 and the two-write program works. After `accel` falls, the mode is 0 and a half-entered bypass program is dropped.
- R9: While `hw_rst_n` is 0 the interpreter returns to idle with mode 0, writes are ignored and no strobe is issued.
- R10: After the first cycle in which `hw_rst_n` is sampled 0, `ready` stays 0 for LONG_DLY cycles if `op_busy` was 1, or SHORT_DLY cycles otherwise, and for as long as `hw_rst_n` is 0. Writes are ignored while `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| hw_rst_n | input | 1 | Hardware reset request, active low |
| accel | input | 1 | Acceleration request, forces bypass mode |
| op_busy | input | 1 | Controller reports an embedded operation in progress |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write word address |
| wr_data | input | DATA_W | Bus write data |
| rd_addr | input | ADDR_W | Current read address for the bank view |
| prog_stb | output | 1 | Program command pulse |
| asel_enter_stb | output | 1 | Identifier mode entry pulse |
| asel_exit_stb | output | 1 | Identifier mode exit pulse |
| cmd_addr | output | ADDR_W | Address belonging to the current strobe |
| cmd_data | output | DATA_W | Data belonging to the current strobe |
| mode | output | 2 | 0 read, 1 identifier, 2 bypass |
| asel_bank | output | 3 | Bank latched for identifier mode |
| id_sel | output | 1 | Current read should return identifier data |
| ready | output | 1 | Interpreter accepts writes |

## Verification
The bench builds the block with LONG_DLY = 12 and SHORT_DLY = 3. Both recovery windows are therefore short enough that the edge where `ready` rises can be located exactly, one cycle early and on time, for busy and idle reset cases. The 22-bit address keeps the real bank field position, so identifier mode for bank 5 can be compared against reads in bank 2 and bank 5.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_READ = 2'd0,
        MODE_ASEL = 2'd1,
        MODE_BYP  = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_UNLK1,
        SEQ_UNLK2,
        SEQ_PGM_DATA,
        SEQ_BYP_DATA,
        SEQ_BYP_EXIT
    } seq_e;

    localparam int LOW_W = 11;
    localparam logic [LOW_W-1:0] ADR_FIRST  = 11'h555;
    localparam logic [LOW_W-1:0] ADR_SECOND = 11'h2AA;

    localparam logic [7:0] KEY_A     = 8'hAA;
    localparam logic [7:0] KEY_B     = 8'h55;
    localparam logic [7:0] OP_PGM    = 8'hA0;
    localparam logic [7:0] OP_BYPASS = 8'h20;
    localparam logic [7:0] OP_IDENT  = 8'h90;
    localparam logic [7:0] OP_LEAVE  = 8'h00;
    localparam logic [7:0] OP_READ   = 8'hF0;

endpackage

// File: rtl/flash_rst_timer.sv
module flash_rst_timer #(
    parameter int LONG_DLY  = 600,
    parameter int SHORT_DLY = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_rst_n,
    input  logic op_busy,
    output logic ready
);
    localparam int CNT_W = $clog2(LONG_DLY + 1);

    logic             hw_prev_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hw_prev_q <= 1'b1;
            cnt_q     <= '0;
        end else begin
            hw_prev_q <= hw_rst_n;
            if (!hw_rst_n && hw_prev_q) begin
                cnt_q <= op_busy ? CNT_W'(LONG_DLY) : CNT_W'(SHORT_DLY);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign ready = hw_rst_n && (cnt_q == '0);

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_rst_n,
    input  logic              wr_ok,
    input  logic              accel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              prog_stb,
    output logic              asel_enter_stb,
    output logic              asel_exit_stb,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output mode_e             mode_q,
    output logic [BANK_W-1:0] bank_q
);
    seq_e              seq_q, seq_d;
    mode_e             mode_d;
    logic [BANK_W-1:0] bank_d;
    logic              accel_q;
    logic              pgm_d, ent_d, ext_d;
    logic [7:0]        op;
    logic              at_first, at_second, byp, acc_fall;

    assign op        = wr_data[7:0];
    assign at_first  = (wr_addr[LOW_W-1:0] == ADR_FIRST);
    assign at_second = (wr_addr[LOW_W-1:0] == ADR_SECOND);
    assign byp       = accel || (mode_q == MODE_BYP);
    assign acc_fall  = accel_q && !accel;

    always_comb begin
        seq_d  = seq_q;
        mode_d = mode_q;
        bank_d = bank_q;
        pgm_d  = 1'b0;
        ent_d  = 1'b0;
        ext_d  = 1'b0;
        if (acc_fall) begin
            seq_d  = SEQ_IDLE;
            mode_d = MODE_READ;
        end else if (wr_ok) begin
            unique case (seq_q)
                SEQ_IDLE: begin
                    if (byp) begin
                        if (op == OP_PGM)        seq_d = SEQ_BYP_DATA;
                        else if (op == OP_IDENT) seq_d = SEQ_BYP_EXIT;
                    end else if (op == OP_READ) begin
                        ext_d  = (mode_q == MODE_ASEL);
                        mode_d = MODE_READ;
                    end else if (op == KEY_A && at_first) begin
                        seq_d = SEQ_UNLK1;
                    end
                end
                SEQ_UNLK1: begin
                    seq_d = (op == KEY_B && at_second) ? SEQ_UNLK2 : SEQ_IDLE;
                end
                SEQ_UNLK2: begin
                    seq_d = SEQ_IDLE;
                    if (at_first) begin
                        if (op == OP_PGM) begin
                            seq_d = SEQ_PGM_DATA;
                        end else if (op == OP_BYPASS) begin
                            mode_d = MODE_BYP;
                        end else if (op == OP_IDENT) begin
                            mode_d = MODE_ASEL;
                            bank_d = wr_addr[ADDR_W-1 -: BANK_W];
                            ent_d  = 1'b1;
                        end
                    end
                end
                SEQ_PGM_DATA, SEQ_BYP_DATA: begin
                    pgm_d = 1'b1;
                    seq_d = SEQ_IDLE;
                end
                SEQ_BYP_EXIT: begin
                    if (op == OP_LEAVE) mode_d = MODE_READ;
                    seq_d = SEQ_IDLE;
                end
                default: seq_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q   <= SEQ_IDLE;
            mode_q  <= MODE_READ;
            bank_q  <= '0;
            accel_q <= 1'b0;
        end else if (!hw_rst_n) begin
            seq_q   <= SEQ_IDLE;
            mode_q  <= MODE_READ;
            accel_q <= accel;
        end else begin
            seq_q   <= seq_d;
            mode_q  <= mode_d;
            bank_q  <= bank_d;
            accel_q <= accel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_stb       <= 1'b0;
            asel_enter_stb <= 1'b0;
            asel_exit_stb  <= 1'b0;
            cmd_addr       <= '0;
            cmd_data       <= '0;
        end else begin
            prog_stb       <= pgm_d && hw_rst_n;
            asel_enter_stb <= ent_d && hw_rst_n;
            asel_exit_stb  <= ext_d && hw_rst_n;
            if (wr_ok && hw_rst_n) begin
                cmd_addr <= wr_addr;
                cmd_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/flash_bank_view.sv
module flash_bank_view
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int BANK_W = 3
) (
    input  mode_e             mode_q,
    input  logic [BANK_W-1:0] bank_q,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              id_sel
);
    assign id_sel = (mode_q == MODE_ASEL) && (rd_addr[ADDR_W-1 -: BANK_W] == bank_q);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int LONG_DLY  = 600,
    parameter int SHORT_DLY = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_rst_n,
    input  logic              accel,
    input  logic              op_busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prog_stb,
    output logic              asel_enter_stb,
    output logic              asel_exit_stb,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [1:0]        mode,
    output logic [2:0]        asel_bank,
    output logic              id_sel,
    output logic              ready
);
    localparam int BANK_W = 3;

    mode_e mode_q;
    logic  wr_ok;

    assign wr_ok = wr_en && ready;

    flash_rst_timer #(
        .LONG_DLY (LONG_DLY),
        .SHORT_DLY(SHORT_DLY)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_rst_n(hw_rst_n),
        .op_busy (op_busy),
        .ready   (ready)
    );

    flash_cmd_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .BANK_W(BANK_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hw_rst_n      (hw_rst_n),
        .wr_ok         (wr_ok),
        .accel         (accel),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .prog_stb      (prog_stb),
        .asel_enter_stb(asel_enter_stb),
        .asel_exit_stb (asel_exit_stb),
        .cmd_addr      (cmd_addr),
        .cmd_data      (cmd_data),
        .mode_q        (mode_q),
        .bank_q        (asel_bank)
    );

    flash_bank_view #(
        .ADDR_W(ADDR_W),
        .BANK_W(BANK_W)
    ) u_view (
        .mode_q (mode_q),
        .bank_q (asel_bank),
        .rd_addr(rd_addr),
        .id_sel (id_sel)
    );

    assign mode = accel ? 2'(MODE_BYP) : 2'(mode_q);

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_rst_n,
    input logic       accel,
    input logic       wr_en,
    input logic       prog_stb,
    input logic       asel_enter_stb,
    input logic       asel_exit_stb,
    input logic [1:0] mode,
    input logic       ready
);
    // R2
    pgm_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |-> $past(wr_en));

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, asel_enter_stb, asel_exit_stb}));

    // R6
    enter_sets_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asel_enter_stb |-> (mode == 2'd1 || accel));

    // R8
    accel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(accel) |=> (mode == 2'd0 || accel));

    // R9
    hold_no_pgm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_rst_n |=> !prog_stb);

    // R9
    hold_read_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_rst_n && !accel) |=> (mode == 2'd0 || accel));

    // R10
    recover_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hw_rst_n) |=> !ready);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_rst_n      (hw_rst_n),
    .accel         (accel),
    .wr_en         (wr_en),
    .prog_stb      (prog_stb),
    .asel_enter_stb(asel_enter_stb),
    .asel_exit_stb (asel_exit_stb),
    .mode          (mode),
    .ready         (ready)
);

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int LD = 12;
    localparam int SD = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_rst_n = 1'b1;
    logic          accel = 1'b0;
    logic          op_busy = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          prog_stb, asel_enter_stb, asel_exit_stb, id_sel, ready;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic [1:0]    mode;
    logic [2:0]    asel_bank;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .LONG_DLY(LD), .SHORT_DLY(SD)) u0 (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .accel(accel),
        .op_busy(op_busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .prog_stb(prog_stb), .asel_enter_stb(asel_enter_stb),
        .asel_exit_stb(asel_exit_stb), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .mode(mode), .asel_bank(asel_bank), .id_sel(id_sel), .ready(ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one bus write; on return the cycle after the write is visible
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0055);
    endtask

    task automatic t_reset();
        check("R1 mode", 32'(mode), 0);
        check("R1 ready", 32'(ready), 1);
        check("R1 strobes", 32'({prog_stb, asel_enter_stb, asel_exit_stb}), 0);
    endtask

    task automatic t_program();
        unlock();
        wr(22'h555, 16'h00A0);
        check("R2 no early pgm", 32'(prog_stb), 0);
        wr(22'h12345, 16'hBEEF);
        check("R2 pgm strobe", 32'(prog_stb), 1);
        check("R2 pgm addr", 32'(cmd_addr), 32'h12345);
        check("R2 pgm data", 32'(cmd_data), 32'hBEEF);
        @(negedge clk);
        check("R2 one pulse", 32'(prog_stb), 0);
    endtask

    task automatic t_broken();
        wr(22'h555, 16'h00AA);
        wr(22'h2AA, 16'h0056);
        wr(22'h555, 16'h00A0);
        wr(22'h00100, 16'h1111);
        check("R3 no pgm", 32'(prog_stb), 0);
        check("R3 mode", 32'(mode), 0);
    endtask

    task automatic t_bypass();
        unlock();
        wr(22'h555, 16'h0020);
        check("R4 mode bypass", 32'(mode), 2);
        wr(22'h00777, 16'h00A0);
        check("R4 no early pgm", 32'(prog_stb), 0);
        wr(22'h3F000, 16'h4242);
        check("R4 two-cycle pgm", 32'(prog_stb), 1);
        check("R4 pgm data", 32'(cmd_data), 32'h4242);
        wr(22'h0, 16'h0090);
        wr(22'h0, 16'h0012);
        check("R5 stays bypass", 32'(mode), 2);
        wr(22'h0, 16'h0090);
        wr(22'h0, 16'h0000);
        check("R5 exit", 32'(mode), 0);
    endtask

    task automatic t_ident();
        unlock();
        wr({3'd5, 19'h00555}, 16'h0090);
        check("R6 enter pulse", 32'(asel_enter_stb), 1);
        check("R6 mode", 32'(mode), 1);
        check("R6 bank", 32'(asel_bank), 5);
        rd_addr = {3'd5, 19'h00010};
        #1 check("R7 own bank", 32'(id_sel), 1);
        rd_addr = {3'd2, 19'h00010};
        #1 check("R7 other bank", 32'(id_sel), 0);
        wr(22'h0, 16'h00F0);
        check("R6 exit pulse", 32'(asel_exit_stb), 1);
        check("R6 read mode", 32'(mode), 0);
    endtask

    task automatic t_accel();
        @(negedge clk);
        accel = 1'b1;
        #1 check("R8 forced bypass", 32'(mode), 2);
        wr(22'h0, 16'h00A0);
        wr(22'h00200, 16'h5A5A);
        check("R8 accel pgm", 32'(prog_stb), 1);
        wr(22'h0, 16'h00A0);
        @(negedge clk);
        accel = 1'b0;
        @(negedge clk);
        check("R8 normal mode", 32'(mode), 0);
        wr(22'h00300, 16'h6666);
        check("R8 half cmd dropped", 32'(prog_stb), 0);
    endtask

    task automatic t_hold();
        unlock();
        wr(22'h555, 16'h0020);
        @(negedge clk);
        hw_rst_n = 1'b0;
        wr(22'h0, 16'h00A0);
        check("R9 mode read", 32'(mode), 0);
        check("R10 not ready", 32'(ready), 0);
        hw_rst_n = 1'b1;
        for (int i = 0; i < 40 && !ready; i++) @(negedge clk);
        wr(22'h00400, 16'h7777);
        check("R9 write ignored", 32'(prog_stb), 0);
        check("R9 still read", 32'(mode), 0);
    endtask

    task automatic t_recover(input logic busy, input int dly, input string tag);
        @(negedge clk);
        op_busy = busy;
        hw_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        hw_rst_n = 1'b1;
        op_busy = 1'b0;
        repeat (dly - 2) @(negedge clk);
        check({tag, " early"}, 32'(ready), 0);
        @(negedge clk);
        check({tag, " on time"}, 32'(ready), 1);
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_broken();
        t_bypass();
        t_ident();
        t_accel();
        t_hold();
        t_recover(1'b1, LD, "R10 busy");
        t_recover(1'b0, SD, "R10 idle");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule